// File: doc/BRIEF.md
# Infrared Remote Carrier and Envelope Generator

This block produces the waveform for an infrared transmitter pin. A carrier generator makes a square wave whose high and low intervals are set on their own, each as a count of clock periods. An envelope timer cuts that carrier into marks and spaces. During a mark the pin carries the carrier. During a space the pin is held low. The mark and space lengths come from two separate duration registers. A readable counter shows how far the current phase has run.

Software programs the block through a small write port. A mode register holds two enables: one for remote operation and one for data-pulse generation. The envelope runs only while both are set. Otherwise the pin follows a direct output bit that software sets. A one-cycle interrupt marks the start of each new phase, so software can load the next duration in time.

The envelope is a three-state machine. DIRECT drives the pin from the software bit. MARK drives the carrier. SPACE holds the pin low. The transitions are:
- T_START: DIRECT to MARK, when both enables are set.
- T_MARK_END: MARK to SPACE, when the counter reaches the mark duration.
- T_SPACE_END: SPACE to MARK, when the counter reaches the space duration.
- T_STOP: MARK or SPACE to DIRECT, when either enable is clear.

Top module: `ir_remote_gen`

## Requirements
- R1: After reset, `ir_out`, `env_count` and `phase_irq` are 0. Both carrier selects reset to 63. Both durations reset to 255, so the first mark after reset lasts 256 cycles.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`, using this map: 0 is carrier high select (bits 5:0), 1 is carrier low select (bits 5:0), 2 is mark duration, 3 is space duration, 4 is mode (bit 0 run enable, bit 1 pulse enable) and 5 is the direct output bit (bit 0). Writes to addresses 6 and 7 have no effect.
- R3: While the mode register does not hold both enables, the machine is in DIRECT and `ir_out` equals the stored direct output bit.
- R4: When the machine is in DIRECT and the mode register holds both enables, T_START is taken at the next edge. `env_count` then reads 0 and `ir_out` reads 1.
- R5: A mark lasts mark duration + 1 cycles. During the mark, `env_count` steps 0, 1, ... up to the mark duration, and then T_MARK_END is taken.
- R6: A space lasts space duration + 1 cycles with `ir_out` low. Then T_SPACE_END is taken.
- R7: Within a mark the carrier starts high. It stays high for the high select in cycles, then low for the low select in cycles, and repeats. The carrier restarts high at every mark.
- R8: A carrier select of 0 acts as 1 cycle.
- R9: `phase_irq` is high for exactly the first cycle of each new mark or space entered through T_MARK_END or T_SPACE_END, and is low at all other times.
- R10: Clearing either enable takes T_STOP at the next edge. `env_count` returns to 0 and no interrupt is raised.
- R11: In MARK or SPACE, `env_count` is the number of cycles already spent in the current phase. In DIRECT it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ir_out | output | 1 | Infrared drive pin |
| env_count | output | 8 | Elapsed cycles in the current phase |
| phase_irq | output | 1 | One-cycle pulse at the start of a new phase |

## Verification
The assertions assume three things. The mark and space durations are not lowered below the running `env_count` in the middle of a phase. The carrier selects do not change during a mark. If either happened, the phase could run on until the counter wraps, or the carrier pattern would stop being periodic.

The stimulus keeps within these limits. It changes carrier selects and durations only while the machine is in DIRECT, and it starts each mark only after the registers are settled. Inside these limits, the bench's behavioural model can predict every output cycle by cycle.

// File: rtl/ir_remote_pkg.sv
package ir_remote_pkg;
    typedef enum logic [1:0] {
        PH_DIRECT = 2'd0,
        PH_MARK   = 2'd1,
        PH_SPACE  = 2'd2
    } phase_e;

    localparam int unsigned ADDR_CAR_HI = 0;
    localparam int unsigned ADDR_CAR_LO = 1;
    localparam int unsigned ADDR_MARK   = 2;
    localparam int unsigned ADDR_SPACE  = 3;
    localparam int unsigned ADDR_MODE   = 4;
    localparam int unsigned ADDR_OUTBIT = 5;
endpackage

// File: rtl/ir_remote_regs.sv
module ir_remote_regs #(
    parameter int SEL_W  = 6,
    parameter int DUR_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUR_W-1:0]  wr_data,
    output logic [SEL_W-1:0]  hi_sel,
    output logic [SEL_W-1:0]  lo_sel,
    output logic [DUR_W-1:0]  mark_dur,
    output logic [DUR_W-1:0]  space_dur,
    output logic              run_en,
    output logic              pulse_en,
    output logic              out_bit
);
    import ir_remote_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_sel    <= '1;
            lo_sel    <= '1;
            mark_dur  <= '1;
            space_dur <= '1;
            run_en    <= 1'b0;
            pulse_en  <= 1'b0;
            out_bit   <= 1'b0;
        end else if (wr_en) begin
            case (int'(wr_addr))
                ADDR_CAR_HI: hi_sel    <= wr_data[SEL_W-1:0];
                ADDR_CAR_LO: lo_sel    <= wr_data[SEL_W-1:0];
                ADDR_MARK:   mark_dur  <= wr_data;
                ADDR_SPACE:  space_dur <= wr_data;
                ADDR_MODE: begin
                    run_en   <= wr_data[0];
                    pulse_en <= wr_data[1];
                end
                ADDR_OUTBIT: out_bit   <= wr_data[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ir_remote_carrier.sv
module ir_remote_carrier #(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] hi_sel,
    input  logic [SEL_W-1:0] lo_sel,
    output logic             car_hi
);
    logic [SEL_W-1:0] cnt;
    logic [SEL_W-1:0] hi_len;
    logic [SEL_W-1:0] lo_len;
    logic [SEL_W-1:0] lim;

    always_comb begin
        hi_len = (hi_sel == '0) ? SEL_W'(1) : hi_sel;
        lo_len = (lo_sel == '0) ? SEL_W'(1) : lo_sel;
        lim    = car_hi ? hi_len : lo_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            car_hi <= 1'b1;
            cnt    <= '0;
        end else if (cnt == lim - SEL_W'(1)) begin
            car_hi <= ~car_hi;
            cnt    <= '0;
        end else begin
            cnt    <= cnt + SEL_W'(1);
        end
    end
endmodule

// File: rtl/ir_remote_envelope.sv
module ir_remote_envelope #(
    parameter int DUR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       env_on,
    input  logic [DUR_W-1:0]           mark_dur,
    input  logic [DUR_W-1:0]           space_dur,
    output ir_remote_pkg::phase_e      ph,
    output logic [DUR_W-1:0]           cnt,
    output logic                       irq
);
    import ir_remote_pkg::*;

    phase_e           nxt_ph;
    logic [DUR_W-1:0] nxt_cnt;
    logic             nxt_irq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_DIRECT;
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            ph  <= nxt_ph;
            cnt <= nxt_cnt;
            irq <= nxt_irq;
        end
    end

    always_comb begin
        nxt_ph  = ph;
        nxt_cnt = cnt;
        nxt_irq = 1'b0;
        unique case (ph)
            PH_DIRECT: begin
                nxt_cnt = '0;
                if (env_on) nxt_ph = PH_MARK;
            end
            PH_MARK: begin
                if (!env_on) begin
                    nxt_ph  = PH_DIRECT;
                    nxt_cnt = '0;
                end else if (cnt == mark_dur) begin
                    nxt_ph  = PH_SPACE;
                    nxt_cnt = '0;
                    nxt_irq = 1'b1;
                end else begin
                    nxt_cnt = cnt + DUR_W'(1);
                end
            end
            PH_SPACE: begin
                if (!env_on) begin
                    nxt_ph  = PH_DIRECT;
                    nxt_cnt = '0;
                end else if (cnt == space_dur) begin
                    nxt_ph  = PH_MARK;
                    nxt_cnt = '0;
                    nxt_irq = 1'b1;
                end else begin
                    nxt_cnt = cnt + DUR_W'(1);
                end
            end
            default: begin
                nxt_ph  = PH_DIRECT;
                nxt_cnt = '0;
            end
        endcase
    end
endmodule

// File: rtl/ir_remote_gen.sv
module ir_remote_gen #(
    parameter int SEL_W  = 6,
    parameter int DUR_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUR_W-1:0]  wr_data,
    output logic              ir_out,
    output logic [DUR_W-1:0]  env_count,
    output logic              phase_irq
);
    import ir_remote_pkg::*;

    logic [SEL_W-1:0] hi_sel;
    logic [SEL_W-1:0] lo_sel;
    logic [DUR_W-1:0] mark_dur;
    logic [DUR_W-1:0] space_dur;
    logic             run_en;
    logic             pulse_en;
    logic             out_bit;
    logic             env_on;
    logic             car_hi;
    phase_e           ph;

    ir_remote_regs #(.SEL_W(SEL_W), .DUR_W(DUR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hi_sel    (hi_sel),
        .lo_sel    (lo_sel),
        .mark_dur  (mark_dur),
        .space_dur (space_dur),
        .run_en    (run_en),
        .pulse_en  (pulse_en),
        .out_bit   (out_bit)
    );

    assign env_on = run_en && pulse_en;

    ir_remote_envelope #(.DUR_W(DUR_W)) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .env_on    (env_on),
        .mark_dur  (mark_dur),
        .space_dur (space_dur),
        .ph        (ph),
        .cnt       (env_count),
        .irq       (phase_irq)
    );

    ir_remote_carrier #(.SEL_W(SEL_W)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ph == PH_MARK),
        .hi_sel (hi_sel),
        .lo_sel (lo_sel),
        .car_hi (car_hi)
    );

    always_comb begin
        unique case (ph)
            PH_MARK:  ir_out = car_hi;
            PH_SPACE: ir_out = 1'b0;
            default:  ir_out = out_bit;
        endcase
    end
endmodule

// File: rtl/ir_remote_chk.sv
module ir_remote_chk #(
    parameter int DUR_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input ir_remote_pkg::phase_e ph,
    input logic                  env_on,
    input logic                  irq,
    input logic [DUR_W-1:0]      cnt,
    input logic                  ir_out
);
    import ir_remote_pkg::*;

    p_start_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DIRECT && env_on) |=> (ph == PH_MARK && cnt == '0));

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_DIRECT && ph == $past(ph)) |-> (cnt == DUR_W'($past(cnt) + 1'b1)));

    p_irq_newphase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ph != PH_DIRECT && ph != $past(ph) && cnt == '0));

    p_mark_begins_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_MARK && $past(ph) != PH_MARK) |-> ir_out);

    p_space_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SPACE) |-> !ir_out);

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!env_on && ph != PH_DIRECT) |=> (ph == PH_DIRECT && cnt == '0 && !irq));
endmodule

bind ir_remote_gen ir_remote_chk #(.DUR_W(DUR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .env_on (env_on),
    .irq    (phase_irq),
    .cnt    (env_count),
    .ir_out (ir_out)
);

// File: tb/test_ir_remote_gen.sv
module test_ir_remote_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ir_out;
    logic [7:0] env_count;
    logic       phase_irq;

    int nchk = 0;
    int nfail = 0;
    bit cmp_en = 1'b0;

    // reference model state
    int m_h = 63, m_l = 63, m_mk = 255, m_sp = 255, m_mode = 0, m_bit = 0;
    int m_ph = 0, m_el = 0, m_irq = 0;
    bit m_on;

    ir_remote_gen i_ir_remote_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ir_out    (ir_out),
        .env_count (env_count),
        .phase_irq (phase_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_out();
        int h, l;
        h = (m_h == 0) ? 1 : m_h;
        l = (m_l == 0) ? 1 : m_l;
        if (m_ph == 1) return ((m_el % (h + l)) < h) ? 1 : 0;
        if (m_ph == 2) return 0;
        return m_bit;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 63; m_l = 63; m_mk = 255; m_sp = 255;
            m_mode = 0; m_bit = 0; m_ph = 0; m_el = 0; m_irq = 0;
        end else begin
            m_on  = (m_mode & 3) == 3;
            m_irq = 0;
            case (m_ph)
                0: if (m_on) begin m_ph = 1; m_el = 0; end
                1: if (!m_on) begin m_ph = 0; m_el = 0; end
                   else if (m_el == m_mk) begin m_ph = 2; m_el = 0; m_irq = 1; end
                   else m_el++;
                default: if (!m_on) begin m_ph = 0; m_el = 0; end
                   else if (m_el == m_sp) begin m_ph = 1; m_el = 0; m_irq = 1; end
                   else m_el++;
            endcase
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_h = wr_data & 63;
                    1: m_l = wr_data & 63;
                    2: m_mk = wr_data;
                    3: m_sp = wr_data;
                    4: m_mode = wr_data & 3;
                    5: m_bit = wr_data & 1;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk((m_ph == 0) ? "R3 direct pin" : (m_ph == 1) ? "R7 mark carrier" : "R6 space pin",
                int'(ir_out), exp_out());
            chk("R11 env_count", int'(env_count), m_el);
            chk("R9 phase_irq", int'(phase_irq), m_irq);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!phase_irq && n < 1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ir_out", int'(ir_out), 0);
        chk("R1 reset env_count", int'(env_count), 0);
        chk("R1 reset phase_irq", int'(phase_irq), 0);
        cmp_en = 1'b1;

        // R3 direct output
        wr(5, 1);
        chk("R3 direct bit high", int'(ir_out), 1);
        wr(4, 1);
        @(negedge clk);
        chk("R3 run only stays direct", int'(ir_out), 1);
        chk("R3 run only count", int'(env_count), 0);
        wr(5, 0);
        chk("R3 direct bit low", int'(ir_out), 0);

        // R2 unmapped addresses ignored
        wr(6, 255);
        wr(7, 255);
        @(negedge clk);
        chk("R2 unmapped write ignored", int'(ir_out), 0);

        // R1 defaults: 256-cycle mark
        wr(4, 3);
        @(negedge clk);
        chk("R4 start count", int'(env_count), 0);
        chk("R4 start high", int'(ir_out), 1);
        wait_irq(n);
        chk("R1 default mark length", n, 256);
        chk("R6 space after mark", int'(ir_out), 0);

        // R10 stop
        wr(4, 0);
        @(negedge clk);
        chk("R10 stop count", int'(env_count), 0);
        chk("R10 stop irq", int'(phase_irq), 0);
        chk("R10 stop pin direct", int'(ir_out), 0);

        // R7 carrier 3 high / 2 low, R5 mark 10, R6 space 6
        wr(0, 3); wr(1, 2); wr(2, 10); wr(3, 6);
        wr(4, 3);
        @(negedge clk);
        chk("R4 restart count", int'(env_count), 0);
        for (int i = 0; i < 10; i++) begin
            if (i > 0) @(negedge clk);
            chk("R7 carrier shape", int'(ir_out), ((i % 5) < 3) ? 1 : 0);
        end
        wait_irq(n);
        chk("R5 mark length", 9 + n, 11);
        chk("R6 space starts low", int'(ir_out), 0);
        wait_irq(n);
        chk("R6 space length", n, 7);
        chk("R7 mark restarts high", int'(ir_out), 1);
        repeat (30) @(negedge clk);

        // R8 zero selects
        wr(4, 0);
        wr(0, 0); wr(1, 0); wr(2, 3); wr(3, 0);
        wr(4, 3);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) @(negedge clk);
            chk("R8 zero select toggles", int'(ir_out), (i % 2 == 0) ? 1 : 0);
        end
        wait_irq(n);
        wait_irq(n);
        chk("R6 zero space one cycle", n, 1);
        repeat (20) @(negedge clk);

        // R10 clear pulse enable with direct bit set
        wr(5, 1);
        wr(4, 2);
        @(negedge clk);
        chk("R10 pulse off direct", int'(ir_out), 1);
        chk("R10 pulse off count", int'(env_count), 0);
        repeat (5) @(negedge clk);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule